// File: doc/BRIEF.md
# Real-Time Clock Alarm Matcher

This block watches the running calendar time of a real-time clock, held in BCD, and compares it with a programmed alarm time. The alarm time has five fields: month, day, hour, minute and second. Five repeat bits sit in spare high bits of those alarm bytes. Together they pick how often the alarm recurs: every second, minute, hour, day, month or year. The repeat setting masks off progressively more of the time fields from the comparison.

The comparison is made once per second. The time counter outside the block pulses `sec_tick` when the new second is on the time inputs. When every selected field is equal on that pulse, an alarm flag is set. If the enable bit is set, an active-low interrupt is driven. Software reaches the alarm and flag bytes through a simple register port: a write strobe, and a combinational read mux. Reading the flag byte clears the flag.

The block does not count time, does not decode a serial bus and does not make a square wave.

Top module: `rtc_alarm_top`

## Requirements
- R1: Registers at 0x0A (alarm month), 0x0B (alarm day), 0x0C (alarm hour), 0x0D (alarm minute) and 0x0E (alarm second) store all eight written bits and read them back. The flag byte at 0x0F reads the alarm flag at bit 6 and zero in every other bit. All other addresses read 0x00.
- R2: After reset, all alarm bytes read 0x00, the flag reads 0 and `irq_n` is 1.
- R3: The repeat code is {day[6], day[7], hour[7], min[7], sec[7]}, from most to least significant bit. Its six codes select which fields are compared, as follows:
  - 0x1F: none (every second).
  - 0x1E: second.
  - 0x1C: second and minute.
  - 0x18: second, minute and hour.
  - 0x10: second, minute, hour and day.
  - 0x00: all five fields.
- R4: Any other repeat code behaves as 0x1F, so it fires on every second tick.
- R5: The flag can only become set on a cycle with `sec_tick` high. With no tick, equal fields do not set it.
- R6: The comparison uses month bits [4:0], day bits [5:0], hour bits [5:0], minute bits [6:0] and second bits [6:0]. Repeat bits and the other unused high bits never take part.
- R7: Reading 0x0F (`rd_en` high) clears the flag at the next edge. If a match sets the flag in that same cycle, the flag stays set.
- R8: `irq_n` is 0 exactly when the flag is set and the enable bit (bit 7 of 0x0A) is 1.
- R9: A `sec_tick` in a cycle that writes any of 0x0A to 0x0E does not set the flag.
- R10: Writes to 0x0F, or to addresses outside 0x0A to 0x0E, change no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse when a new second is on the time inputs |
| now_mon | input | 8 | Current month, BCD |
| now_day | input | 8 | Current day of month, BCD |
| now_hour | input | 8 | Current hour, BCD |
| now_min | input | 8 | Current minute, BCD |
| now_sec | input | 8 | Current second, BCD |
| addr | input | 5 | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (clears the flag when the address is 0x0F) |
| rd_data | output | 8 | Read data for `addr`, combinational |
| irq_n | output | 1 | Active-low alarm interrupt |

## Verification
The hardest cases to reach are the interactions between the register port and the tick. These are a tick arriving in the same cycle as an alarm-register write, and a flag read landing on the very cycle a match sets the flag. The bench places the write strobe, the read strobe and `sec_tick` on the same negedge-driven cycle. It then checks the flag on the following cycle. For the repeat logic, the bench sweeps all 32 repeat codes. Against each code it applies six time vectors: one that equals the alarm in every field, and five that each differ in exactly one field. The result is compared with a mask computed in the bench.

// File: rtl/rtc_alarm_pkg.sv
// Shared constants and types for the RTC alarm matcher.
package rtc_alarm_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_ALM_MON  = 5'h0A;
    localparam logic [ADDR_W-1:0] A_ALM_DAY  = 5'h0B;
    localparam logic [ADDR_W-1:0] A_ALM_HOUR = 5'h0C;
    localparam logic [ADDR_W-1:0] A_ALM_MIN  = 5'h0D;
    localparam logic [ADDR_W-1:0] A_ALM_SEC  = 5'h0E;
    localparam logic [ADDR_W-1:0] A_FLAGS    = 5'h0F;

    localparam int FLAG_BIT = 6;
    localparam int EN_BIT   = 7;

    // Significant BCD widths of each compared field
    localparam int MON_W  = 5;
    localparam int DAY_W  = 6;
    localparam int HOUR_W = 6;
    localparam int MIN_W  = 7;
    localparam int SEC_W  = 7;

    typedef enum logic [4:0] {
        RPT_SEC  = 5'h1F,
        RPT_MIN  = 5'h1E,
        RPT_HOUR = 5'h1C,
        RPT_DAY  = 5'h18,
        RPT_MON  = 5'h10,
        RPT_YEAR = 5'h00
    } rpt_code_e;

    typedef struct packed {
        logic mon;
        logic day;
        logic hour;
        logic min;
        logic sec;
    } cmp_sel_t;
endpackage

// File: rtl/rtc_alarm_regs.sv
// Alarm byte storage with write decode and read mux.
// Assumes a single-cycle write strobe; flag byte handled elsewhere.
module rtc_alarm_regs
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] alm_mon,
    output logic [DATA_W-1:0] alm_day,
    output logic [DATA_W-1:0] alm_hour,
    output logic [DATA_W-1:0] alm_min,
    output logic [DATA_W-1:0] alm_sec,
    output logic              alm_wr,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam int NREG = 5;

    logic [DATA_W-1:0] store [NREG];
    logic [NREG-1:0]   hit;

    // Decode which alarm byte the address selects
    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            hit[i] = (addr == A_ALM_MON + ADDR_W'(i));
        end
    end

    assign alm_wr = wr_en && (hit != '0);

    // One storage byte per alarm register
    for (genvar g = 0; g < NREG; g++) begin : g_byte
        // Load on a write that targets this byte
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                store[g] <= '0;
            end else if (wr_en && hit[g]) begin
                store[g] <= wr_data;
            end
        end
    end

    assign alm_mon  = store[0];
    assign alm_day  = store[1];
    assign alm_hour = store[2];
    assign alm_min  = store[3];
    assign alm_sec  = store[4];

    // Read mux over alarm bytes, zero elsewhere
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (hit[i]) reg_rdata = store[i];
        end
    end

    // R10
    foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit[0]) |=> $stable(store[0]))
        else $error("alarm month changed by foreign write");
endmodule

// File: rtl/rtc_alarm_rptdec.sv
// Turns the five scattered repeat bits into a per-field compare select.
// Assumes the codes listed in the package; anything else means every second.
module rtc_alarm_rptdec
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] alm_day,
    input  logic [DATA_W-1:0] alm_hour,
    input  logic [DATA_W-1:0] alm_min,
    input  logic [DATA_W-1:0] alm_sec,
    output cmp_sel_t          sel
);
    logic [4:0] code;

    assign code = {alm_day[6], alm_day[7], alm_hour[7], alm_min[7], alm_sec[7]};

    // Map repeat code to compared fields
    always_comb begin
        unique case (code)
            RPT_MIN:  sel = '{mon: 1'b0, day: 1'b0, hour: 1'b0, min: 1'b0, sec: 1'b1};
            RPT_HOUR: sel = '{mon: 1'b0, day: 1'b0, hour: 1'b0, min: 1'b1, sec: 1'b1};
            RPT_DAY:  sel = '{mon: 1'b0, day: 1'b0, hour: 1'b1, min: 1'b1, sec: 1'b1};
            RPT_MON:  sel = '{mon: 1'b0, day: 1'b1, hour: 1'b1, min: 1'b1, sec: 1'b1};
            RPT_YEAR: sel = '{mon: 1'b1, day: 1'b1, hour: 1'b1, min: 1'b1, sec: 1'b1};
            default:  sel = '0;
        endcase
    end

    // R3: a coarser field is only compared when all finer ones are
    nested_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel.mon || sel.day || sel.hour || sel.min) |-> sel.sec)
        else $error("compare select not nested");
endmodule

// File: rtl/rtc_alarm_cmp.sv
// Compares selected BCD fields of the alarm against the current time.
// Assumes time inputs are stable in the tick cycle.
module rtc_alarm_cmp
    import rtc_alarm_pkg::*;
(
    input  logic [DATA_W-1:0] alm_mon,
    input  logic [DATA_W-1:0] alm_day,
    input  logic [DATA_W-1:0] alm_hour,
    input  logic [DATA_W-1:0] alm_min,
    input  logic [DATA_W-1:0] alm_sec,
    input  logic [DATA_W-1:0] now_mon,
    input  logic [DATA_W-1:0] now_day,
    input  logic [DATA_W-1:0] now_hour,
    input  logic [DATA_W-1:0] now_min,
    input  logic [DATA_W-1:0] now_sec,
    input  cmp_sel_t          sel,
    output logic              match
);
    cmp_sel_t eq;

    // Per-field equality on significant bits only
    always_comb begin
        eq.mon  = alm_mon[MON_W-1:0]   == now_mon[MON_W-1:0];
        eq.day  = alm_day[DAY_W-1:0]   == now_day[DAY_W-1:0];
        eq.hour = alm_hour[HOUR_W-1:0] == now_hour[HOUR_W-1:0];
        eq.min  = alm_min[MIN_W-1:0]   == now_min[MIN_W-1:0];
        eq.sec  = alm_sec[SEC_W-1:0]   == now_sec[SEC_W-1:0];
    end

    assign match = ((eq | ~sel) == '1);
endmodule

// File: rtl/rtc_alarm_flag.sv
// Holds the alarm flag: set on a qualified tick match, cleared by a read.
// Assumes sec_tick is a single-cycle pulse.
module rtc_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic match,
    input  logic block,
    input  logic rd_clr,
    output logic flag
);
    logic set_now;

    assign set_now = sec_tick && match && !block;

    // Set has priority over read-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_now) begin
            flag <= 1'b1;
        end else if (rd_clr) begin
            flag <= 1'b0;
        end
    end

    // R5
    tick_only_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(sec_tick))
        else $error("flag rose without tick");

    // R9
    write_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && block && !flag) |=> !flag)
        else $error("flag set during alarm write");

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && !(sec_tick && match && !block)) |=> !flag)
        else $error("read did not clear flag");
endmodule

// File: rtl/rtc_alarm_top.sv
// RTC alarm matcher: register port, repeat decode, field compare, flag and IRQ.
// Assumes an external time counter pulses sec_tick with the new time applied.
module rtc_alarm_top
    import rtc_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [DATA_W-1:0] now_mon,
    input  logic [DATA_W-1:0] now_day,
    input  logic [DATA_W-1:0] now_hour,
    input  logic [DATA_W-1:0] now_min,
    input  logic [DATA_W-1:0] now_sec,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_n
);
    logic [DATA_W-1:0] a_mon, a_day, a_hour, a_min, a_sec, reg_rdata;
    logic              alm_wr, match, flag;
    cmp_sel_t          sel;

    rtc_alarm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .alm_mon(a_mon), .alm_day(a_day), .alm_hour(a_hour), .alm_min(a_min),
        .alm_sec(a_sec), .alm_wr(alm_wr), .reg_rdata(reg_rdata)
    );

    rtc_alarm_rptdec u_dec (
        .clk(clk), .rst_n(rst_n), .alm_day(a_day), .alm_hour(a_hour),
        .alm_min(a_min), .alm_sec(a_sec), .sel(sel)
    );

    rtc_alarm_cmp u_cmp (
        .alm_mon(a_mon), .alm_day(a_day), .alm_hour(a_hour), .alm_min(a_min),
        .alm_sec(a_sec), .now_mon(now_mon), .now_day(now_day),
        .now_hour(now_hour), .now_min(now_min), .now_sec(now_sec),
        .sel(sel), .match(match)
    );

    rtc_alarm_flag u_flag (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .match(match),
        .block(alm_wr), .rd_clr(rd_en && (addr == A_FLAGS)), .flag(flag)
    );

    // Read mux: flag byte or alarm bytes
    always_comb begin
        if (addr == A_FLAGS) begin
            rd_data = '0;
            rd_data[FLAG_BIT] = flag;
        end else begin
            rd_data = reg_rdata;
        end
    end

    assign irq_n = !(flag && a_mon[EN_BIT]);

    // R8
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> a_mon[EN_BIT])
        else $error("irq without enable");
endmodule

// File: tb/rtc_alarm_top_test.sv
module rtc_alarm_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [7:0] now_mon = '0, now_day = '0, now_hour = '0, now_min = '0, now_sec = '0;
    logic [4:0] addr = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       irq_n;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rtc_alarm_top uut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .now_mon(now_mon),
        .now_day(now_day), .now_hour(now_hour), .now_min(now_min),
        .now_sec(now_sec), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .irq_n(irq_n)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1 d = rd_data;
    endtask

    task automatic clear_flag();
        @(negedge clk); addr = 5'h0F; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); sec_tick = 1'b1;
        @(negedge clk); sec_tick = 1'b0;
    endtask

    task automatic set_time(input logic [7:0] m, input logic [7:0] d, input logic [7:0] h,
                            input logic [7:0] mi, input logic [7:0] s);
        now_mon = m; now_day = d; now_hour = h; now_min = mi; now_sec = s;
    endtask

    // Fields compared for each repeat code, {mon,day,hour,min,sec}
    function automatic logic [4:0] exp_sel(input logic [4:0] c);
        case (c)
            5'h1E: return 5'b00001;
            5'h1C: return 5'b00011;
            5'h18: return 5'b00111;
            5'h10: return 5'b01111;
            5'h00: return 5'b11111;
            default: return 5'b00000;
        endcase
    endfunction

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2 reset state
        for (int a = 10; a < 16; a++) begin
            peek(5'(a), v); chk("R2 reset byte", v, 8'h00);
        end
        chk("R2 irq_n reset", {7'b0, irq_n}, 8'h01);

        // R1 read back, R10 foreign writes
        wr(5'h0A, 8'hA5); wr(5'h0B, 8'h5A); wr(5'h0C, 8'hC3);
        wr(5'h0D, 8'h3C); wr(5'h0E, 8'hFF);
        wr(5'h0F, 8'hFF); wr(5'h10, 8'h11); wr(5'h09, 8'h22);
        peek(5'h0A, v); chk("R1 mon", v, 8'hA5);
        peek(5'h0B, v); chk("R1 day", v, 8'h5A);
        peek(5'h0C, v); chk("R1 hour", v, 8'hC3);
        peek(5'h0D, v); chk("R1 min", v, 8'h3C);
        peek(5'h0E, v); chk("R1 sec", v, 8'hFF);
        peek(5'h0F, v); chk("R10 flag write ignored", v, 8'h00);
        peek(5'h10, v); chk("R1 unmapped read", v, 8'h00);
        peek(5'h09, v); chk("R1 unmapped read 09", v, 8'h00);

        // R3 R4 sweep over all repeat codes
        set_time(8'h12, 8'h25, 8'h13, 8'h47, 8'h33);
        for (int c = 0; c < 32; c++) begin
            logic [4:0] p, s;
            p = 5'(c);
            s = exp_sel(p);
            wr(5'h0A, 8'h12);
            wr(5'h0B, {p[3], p[4], 6'h25});
            wr(5'h0C, {p[2], 1'b0, 6'h13});
            wr(5'h0D, {p[1], 7'h47});
            wr(5'h0E, {p[0], 7'h33});
            for (int k = -1; k < 5; k++) begin
                logic fire;
                set_time(8'h12, 8'h25, 8'h13, 8'h47, 8'h33);
                if (k == 0) now_sec  = 8'h34;
                if (k == 1) now_min  = 8'h48;
                if (k == 2) now_hour = 8'h14;
                if (k == 3) now_day  = 8'h26;
                if (k == 4) now_mon  = 8'h11;
                fire = (k < 0) ? 1'b1 : !s[k];
                clear_flag();
                tick();
                peek(5'h0F, v);
                chk((s == 0) ? "R4 R3 repeat sweep" : "R3 repeat sweep", v, {1'b0, fire, 6'b0});
            end
        end

        // R6 unused high bit of hour ignored (per-day mode)
        set_time(8'h12, 8'h25, 8'h13, 8'h47, 8'h33);
        wr(5'h0B, 8'hE5); wr(5'h0C, 8'h53); wr(5'h0D, 8'h47); wr(5'h0E, 8'h33);
        now_hour = 8'h53;
        clear_flag(); tick(); peek(5'h0F, v);
        chk("R6 unused hour bit", v, 8'h40);
        now_hour = 8'h13;
        wr(5'h0C, 8'h53);
        clear_flag(); tick(); peek(5'h0F, v);
        chk("R6 hour bit6 masked", v, 8'h40);

        // R5 no tick no set
        clear_flag(); repeat (4) @(negedge clk); peek(5'h0F, v);
        chk("R5 no tick", v, 8'h00);

        // R8 irq with and without enable
        wr(5'h0A, 8'h12); tick();
        @(negedge clk); chk("R8 irq disabled", {7'b0, irq_n}, 8'h01);
        wr(5'h0A, 8'h92);
        @(negedge clk); chk("R8 irq enabled", {7'b0, irq_n}, 8'h00);
        wr(5'h0F, 8'h00); peek(5'h0F, v);
        chk("R10 flag write no clear", v, 8'h40);
        clear_flag();
        @(negedge clk); chk("R8 irq released", {7'b0, irq_n}, 8'h01);
        chk("R7 read clear", rd_data, 8'h00);

        // R7 set beats coincident read
        @(negedge clk); addr = 5'h0F; rd_en = 1'b1; sec_tick = 1'b1;
        @(negedge clk); rd_en = 1'b0; sec_tick = 1'b0;
        #1 chk("R7 set wins", rd_data, 8'h40);

        // R9 write in tick cycle blocks match
        clear_flag();
        @(negedge clk); addr = 5'h0E; wr_data = 8'h33; wr_en = 1'b1; sec_tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; sec_tick = 1'b0;
        peek(5'h0F, v); chk("R9 write blocks", v, 8'h00);
        // unmapped write does not block
        @(negedge clk); addr = 5'h10; wr_data = 8'h00; wr_en = 1'b1; sec_tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; sec_tick = 1'b0;
        peek(5'h0F, v); chk("R9 foreign write no block", v, 8'h40);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule